// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words, `a_in` and `b_in`, and raises exactly one of three flags: A above B, A below B, or A equal to B. The comparison is built from 4-bit slices. Each slice weighs its nibble from bit 3 (most significant) down to bit 0, and only when all four bit pairs match does it pass on a verdict formed from three cascade inputs fed by the next less significant slice. Because only bit weights matter, the block serves plain binary, BCD, or any other code in which a larger value has a larger binary pattern.

The slice reproduces the full cascade-input behaviour, including the combinations that are not one-hot: an asserted equal input wins over the other two, both greater and less asserted give an all-low result, and all three low give both greater and less high. The top level chains `WIDTH/4` slices in series and ties the lowest slice's cascade inputs to greater=0, less=0, equal=1, so a full-word match reports equal. An optional output register stage, selected by `OUT_REG`, cuts the ripple path from the comparison logic.

Top module: `magcmp_top`

## Requirements
- R1: Within a slice, the highest bit position whose A and B bits differ sets the result (greater if the A bit is 1, less if the B bit is 1), and the cascade inputs then have no effect.
- R2: Whenever the compared bits of a slice differ, exactly one of the three slice outputs is high and the equal output is low.
- R3: With all four bit pairs equal and exactly one cascade input high, each slice output takes the value of the cascade input of the same kind.
- R4: With all four bit pairs equal and the equal cascade input high, the slice reports equal only (greater=0, less=0, equal=1), for any greater and less cascade inputs.
- R5: With all four bit pairs equal, the equal cascade input low and both greater and less cascade inputs high, all three slice outputs are low.
- R6: With all four bit pairs equal and all three cascade inputs low, the slice outputs greater=1, less=1, equal=0.
- R7: `WIDTH` must be a multiple of 4; the top chains slices so that each slice's outputs feed the cascade inputs of the next more significant slice, the lowest slice's cascade inputs are fixed at greater=0, less=0, equal=1, and the three top outputs equal the unsigned relations `a_in > b_in`, `a_in < b_in`, `a_in == b_in`.
- R8: With `OUT_REG=1` the outputs show the result for the inputs present at the previous rising edge of `clk`; with `rst` high at a rising edge all three outputs become 0 at that edge.
- R9: With `OUT_REG=0` the outputs are a purely combinational function of `a_in` and `b_in`, and `clk` and `rst` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| a_gt_b | output | 1 | High when A is greater than B |
| a_lt_b | output | 1 | High when A is less than B |
| a_eq_b | output | 1 | High when A equals B |

## Verification
The registered top delivers each verdict one rising edge after the operands are driven, so the bench drives operands on the falling edge, queues the expected flags, and a monitor pops and compares them just after the following rising edge. The combinational top variant and the bare slice have no latency: their outputs are compared a short settling delay after the inputs change, within the same half cycle. The reset check samples the registered outputs on the falling edge that follows a rising edge with reset high.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
    localparam int SLICE_W = 4;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;

    localparam cmp_flags_t CASC_TIE = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};
endpackage

// File: rtl/magcmp_slice.sv
module magcmp_slice
    import magcmp_pkg::*;
(
    input  logic [SLICE_W-1:0] a_nib,
    input  logic [SLICE_W-1:0] b_nib,
    input  cmp_flags_t         casc_in,
    output cmp_flags_t         flags_out
);
    always_comb begin
        logic decided;
        // equal nibbles: verdict formed from the cascade inputs
        flags_out.gt = ~casc_in.eq & ~casc_in.lt;
        flags_out.lt = ~casc_in.eq & ~casc_in.gt;
        flags_out.eq = casc_in.eq;
        decided = 1'b0;
        // scan from the most significant bit; first mismatch wins
        for (int i = SLICE_W - 1; i >= 0; i--) begin
            if (!decided && (a_nib[i] != b_nib[i])) begin
                decided      = 1'b1;
                flags_out.gt = a_nib[i];
                flags_out.lt = b_nib[i];
                flags_out.eq = 1'b0;
            end
        end
    end
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    output cmp_flags_t       flags_out
);
    localparam int NSLICE = WIDTH / SLICE_W;

    if (WIDTH % SLICE_W != 0 || WIDTH < SLICE_W) begin : g_bad_width
        $error("magcmp_chain: WIDTH must be a positive multiple of 4");
    end

    cmp_flags_t link [0:NSLICE];

    assign link[0] = CASC_TIE;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        magcmp_slice u_slice (
            .a_nib     (a_word[g*SLICE_W +: SLICE_W]),
            .b_nib     (b_word[g*SLICE_W +: SLICE_W]),
            .casc_in   (link[g]),
            .flags_out (link[g+1])
        );
    end

    assign flags_out = link[NSLICE];
endmodule

// File: rtl/magcmp_outstage.sv
module magcmp_outstage
    import magcmp_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  cmp_flags_t flags_in,
    output cmp_flags_t flags_out
);
    if (OUT_REG) begin : g_reg
        cmp_flags_t flags_d;
        cmp_flags_t flags_q;

        always_comb begin
            flags_d = flags_in;
            if (rst) begin
                flags_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            flags_q <= flags_d;
        end

        assign flags_out = flags_q;
    end else begin : g_comb
        logic unused_ctrl;
        assign unused_ctrl = clk ^ rst;
        assign flags_out   = flags_in;
    end
endmodule

// File: rtl/magcmp_top.sv
module magcmp_top
    import magcmp_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             a_gt_b,
    output logic             a_lt_b,
    output logic             a_eq_b
);
    cmp_flags_t chain_flags;
    cmp_flags_t out_flags;

    magcmp_chain #(.WIDTH(WIDTH)) u_chain (
        .a_word    (a_in),
        .b_word    (b_in),
        .flags_out (chain_flags)
    );

    magcmp_outstage #(.OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst       (rst),
        .flags_in  (chain_flags),
        .flags_out (out_flags)
    );

    assign a_gt_b = out_flags.gt;
    assign a_lt_b = out_flags.lt;
    assign a_eq_b = out_flags.eq;
endmodule

// File: rtl/magcmp_top_chk.sv
module magcmp_top_chk #(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             a_gt_b,
    input logic             a_lt_b,
    input logic             a_eq_b
);
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $onehot({a_gt_b, a_lt_b, a_eq_b})); // R2

    if (OUT_REG) begin : g_reg_chk
        AST_GT_DELAYED: assert property (@(posedge clk) disable iff (rst || !armed_q)
            a_gt_b == ($past(a_in) > $past(b_in))); // R7

        AST_LT_DELAYED: assert property (@(posedge clk) disable iff (rst || !armed_q)
            a_lt_b == ($past(a_in) < $past(b_in))); // R7

        AST_EQ_DELAYED: assert property (@(posedge clk) disable iff (rst || !armed_q)
            a_eq_b == ($past(a_in) == $past(b_in))); // R8

        AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> (!a_gt_b && !a_lt_b && !a_eq_b)); // R8
    end else begin : g_comb_chk
        AST_GT_DIRECT: assert property (@(posedge clk)
            a_gt_b == (a_in > b_in)); // R9

        AST_LT_DIRECT: assert property (@(posedge clk)
            a_lt_b == (a_in < b_in)); // R9

        AST_EQ_DIRECT: assert property (@(posedge clk)
            a_eq_b == (a_in == b_in)); // R9
    end
endmodule

bind magcmp_top magcmp_top_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/magcmp_top_test.sv
`timescale 1ns/1ps
module magcmp_top_test;
    import magcmp_pkg::*;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         a_gt_b, a_lt_b, a_eq_b;
    logic         c_gt, c_lt, c_eq;

    logic [3:0]   s_a = '0;
    logic [3:0]   s_b = '0;
    cmp_flags_t   s_casc = '0;
    cmp_flags_t   s_out;

    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 1'b0;

    logic [2:0]   exp_q [$];
    string        tag_q [$];

    always #2 clk = ~clk;

    magcmp_top #(.WIDTH(W), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_gt_b(a_gt_b), .a_lt_b(a_lt_b), .a_eq_b(a_eq_b)
    );

    magcmp_top #(.WIDTH(W), .OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_gt_b(c_gt), .a_lt_b(c_lt), .a_eq_b(c_eq)
    );

    magcmp_slice u_slice (
        .a_nib(s_a), .b_nib(s_b), .casc_in(s_casc), .flags_out(s_out)
    );

    // expected slice result, written from the requirement list
    function automatic logic [2:0] slice_ref(input logic [3:0] a, input logic [3:0] b,
                                             input logic gi, input logic li, input logic ei);
        if (a > b) return 3'b100;
        if (a < b) return 3'b010;
        if (ei) return 3'b001;
        if (gi && li) return 3'b000;
        if (!gi && !li) return 3'b110;
        return {gi, li, 1'b0};
    endfunction

    function automatic string slice_tag(input logic [3:0] a, input logic [3:0] b,
                                        input logic gi, input logic li, input logic ei);
        if (a != b) return "R1 R2";
        if (ei) return "R4";
        if (gi && li) return "R5";
        if (!gi && !li) return "R6";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: apply operands on the falling edge and queue the verdict
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        logic [2:0] exp;
        @(negedge clk);
        a_in = a;
        b_in = b;
        exp  = {a > b, a < b, a == b};
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #0.5;
        check("R9", {c_gt, c_lt, c_eq}, exp); // combinational variant, no latency
    endtask

    // monitor: registered result is due one rising edge after driving
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {a_gt_b, a_lt_b, a_eq_b}, e);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // exhaustive single slice: R1..R6
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] vv;
            vv     = v[10:0];
            s_a    = vv[3:0];
            s_b    = vv[7:4];
            s_casc = '{gt: vv[10], lt: vv[9], eq: vv[8]};
            #1;
            check(slice_tag(vv[3:0], vv[7:4], vv[10], vv[9], vv[8]), s_out,
                  slice_ref(vv[3:0], vv[7:4], vv[10], vv[9], vv[8]));
        end

        // reset state of the registered variant: R8
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8", {a_gt_b, a_lt_b, a_eq_b}, 3'b000);
        rst = 1'b0;

        // corner cases of the chain: R7 and R1
        drive(16'h0000, 16'h0000, "R7");
        drive(16'hFFFF, 16'hFFFF, "R7");
        drive(16'h8000, 16'h7FFF, "R1 R7");
        drive(16'h7FFF, 16'h8000, "R1 R7");
        drive(16'h0001, 16'h0000, "R7");
        drive(16'h1234, 16'h1235, "R7");
        drive(16'hA5A5, 16'hA5A5, "R7");
        drive(16'h0F00, 16'h0E00, "R7");

        // random operands, half with all but one nibble shared
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            if (k % 2 == 0) begin
                b = a ^ ((W'($urandom) & 16'h000F) << (4 * (k % 4)));
            end
            drive(a, b, "R7");
        end

        // synchronous reset mid-run clears the outputs: R8
        @(negedge clk);
        a_in = 16'h9000;
        b_in = 16'h1000;
        rst  = 1'b1;
        @(negedge clk);
        check("R8", {a_gt_b, a_lt_b, a_eq_b}, 3'b000);
        rst = 1'b0;
        drive(16'h9000, 16'h1000, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule